// File: doc/BRIEF.md
# Dual-Subtract Absolute Difference Unit

This unit returns the magnitude of the difference between two unsigned words. Both orderings of the subtraction are formed at once by two adders. Each adder adds one operand to the bitwise inverse of the other, with its carry input held at one. The carry output of the adder that forms `a - b` then chooses which of the two differences reaches the output register.

The unit is one pipeline stage. The operands presented at a rising clock edge appear as a magnitude on `q` after that same edge. A new pair can be accepted on every cycle. No negation step follows the subtraction, so the select path goes through one adder's carry chain and one multiplexer.

Top module: `absdiff_dual`

## Requirements
- R1: While `rst_n` is low, `q` is 0, whatever values `a` and `b` carry.
- R2: At each rising edge with `rst_n` high, `q` takes the value |`a` - `b`| of the operands sampled at that edge, treating both as unsigned numbers. The result is visible one clock after the operands are presented.
- R3: Operands 0x1986 and 0x0117 give 0x186F. Operands 0x1986 and 0x1989 give 0x0003.
- R4: Equal operands give 0x0000. This covers 0x0000 with 0x0000, 0x1111 with 0x1111 and 0xFFFF with 0xFFFF.
- R5: Swapping `a` and `b` does not change `q`.
- R6: When `a` >= `b`, the result is `a` - `b`. When `a` < `b`, the result is `b` - `a`. This holds at the boundaries where the operands differ by one, and at the extreme pair 0x0000 with 0xFFFF, which gives 0xFFFF.
- R7: The adder forming `a` + ~`b` + 1 produces a carry output exactly when `a` >= `b`. At least one of the two adders always carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a | input | W (16) | First unsigned operand |
| b | input | W (16) | Second unsigned operand |
| q | output | W (16) | Registered absolute difference |

## Verification
Every result is due exactly one rising edge after its operands are applied. The bench drives each pair on a falling edge. It then reads `q` on the following falling edge, after the one capturing edge has passed and before any new operand is driven. The operand space is covered by a strided 128 by 128 grid, by 20,000 random pairs and by named corner pairs. Each expected value is formed in the bench by subtracting the smaller operand from the larger. The carry rule of R7 is internal to the unit, so it is checked by in-module assertions, and the bench observes its effect through the boundary pairs of R6.

// File: rtl/absdiff_dual.sv
module absdiff_dual #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] q
);

  logic [W-1:0] d_ab, d_ba, pick;
  logic         c_ab, c_ba, use_ba;

  assign {c_ab, d_ab} = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
  assign {c_ba, d_ba} = {1'b0, b} + {1'b0, ~a} + (W+1)'(1);

  assign use_ba = ~c_ab;
  assign pick   = use_ba ? d_ba : d_ab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= pick;
  end

  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> q == '0)
    else $error("R1: q not cleared during reset");

  a_r2_one_cycle_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q == (($past(a) >= $past(b)) ? W'($past(a) - $past(b))
                                                  : W'($past(b) - $past(a))))
    else $error("R2: registered magnitude wrong");

  a_r7_some_adder_carries: assert property (@(posedge clk) disable iff (!rst_n)
    c_ab || c_ba)
    else $error("R7: neither adder carried");

  a_r7_carry_tracks_order: assert property (@(posedge clk) disable iff (!rst_n)
    c_ab == (a >= b))
    else $error("R7: carry does not track operand order");

  a_r4_both_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ab && c_ba) |-> (d_ab == '0 && d_ba == '0))
    else $error("R4: equal operands left a nonzero difference");

endmodule

// File: tb/absdiff_dual_test.sv
module absdiff_dual_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] q;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  absdiff_dual #(.W(W)) uut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .q(q));

  always #10 clk = ~clk;

  function automatic logic [W-1:0] mag(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x >= y) ? x - y : y - x;
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h got=%h expected=%h", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [W-1:0] exp);
    @(negedge clk);
    a = x; b = y;
    @(negedge clk);
    check(req, q, exp);
  endtask

  initial begin
    // R1: reset holds q at zero with nonzero operands
    a = 16'h1234; b = 16'h0001;
    repeat (3) @(negedge clk);
    check("R1", q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", q, 16'h1233);

    apply("R3", 16'h1986, 16'h0117, 16'h186F);
    apply("R3", 16'h1986, 16'h1989, 16'h0003);
    apply("R4", 16'h0000, 16'h0000, 16'h0000);
    apply("R4", 16'h1111, 16'h1111, 16'h0000);
    apply("R4", 16'hFFFF, 16'hFFFF, 16'h0000);
    apply("R5", 16'h0117, 16'h1986, 16'h186F);
    apply("R5", 16'h1989, 16'h1986, 16'h0003);
    apply("R6", 16'h8000, 16'h7FFF, 16'h0001);
    apply("R6", 16'h7FFF, 16'h8000, 16'h0001);
    apply("R6", 16'h0000, 16'hFFFF, 16'hFFFF);
    apply("R6", 16'hFFFF, 16'h0000, 16'hFFFF);
    apply("R7", 16'h0001, 16'h0000, 16'h0001);
    apply("R7", 16'h0000, 16'h0001, 16'h0001);

    // R2: strided grid across the operand space
    for (int i = 0; i < 128; i++)
      for (int j = 0; j < 128; j++) begin
        logic [W-1:0] x, y;
        x = W'(i * 509 + j);
        y = W'(j * 513 + i * 3);
        apply("R2", x, y, mag(x, y));
      end

    // R2/R5: random pairs, each also swapped
    for (int k = 0; k < 10000; k++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      apply("R2", x, y, mag(x, y));
      apply("R5", y, x, mag(x, y));
    end

    // R1: asserting reset mid-run clears q
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", q, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule